// File: doc/BRIEF.md
# Receive Descriptor Frame Writer

This block takes received Ethernet frames, delivered as a byte stream, and stores each one in a memory buffer. Buffers are described by a chain of 16-byte descriptors in the same memory. Software builds the chain, points the block at its first entry, sets the receive-enable input and pulses the receive-demand input. From then on the writer handles each arriving frame in four steps. It reads the current descriptor and checks that the engine owns it. It packs the frame bytes into 32-bit little-endian words and writes them to the buffer. It writes a status word back into the descriptor. It follows the link to the next descriptor.

Two conditions stop the writer. The first is a descriptor that software still owns: the writer raises a descriptor-unavailable status and stays stopped until the next demand pulse. The second is a low receive-enable input, which also reloads the descriptor pointer from the ring base. A frame may be too short (a runt), exceed the programmed maximum, or carry a CRC error. Each such frame is either rejected or accepted with flags, as the per-condition accept inputs select. The trailing CRC can be removed from the stored data.

The frame input is a valid/ready stream. A byte moves on a clock edge where `in_valid` and `in_ready` are both high. The source must hold the byte, `in_last` and `in_crc_err` steady until that edge. The writer lowers `in_ready` while it reads descriptors or waits for a buffer write to be accepted. The memory port uses the same rule: a request is held unchanged until `mem_ready`, and read data is taken in the cycle the request is accepted.

Top module: `rx_desc_writer`

## Requirements
- R1: After reset, `rx_active`, `irq`, `mem_valid`, `in_ready` and all of `int_sts` are 0.
- R2: A `rx_demand` pulse while `rx_on` is high sets `rx_active`. While `rx_on` is low, `rx_active` is 0 and the descriptor pointer is reloaded from `ring_base`. A frame that arrives while the writer is stopped is consumed and discarded, and nothing is written to memory.
- R3: A descriptor at address D holds four words: the status word at D, the buffer address at D+4, a reserved word at D+8 (never accessed) and the next-descriptor address at D+12. The writer clears bits 1:0 of both addresses before using them.
- R4: The owner field is bits 31:30 of the status word, and 2'b10 means the engine owns the descriptor. If any other value is read, the writer sets `int_sts[10]`, clears `rx_active`, discards the frame and leaves the descriptor unchanged.
- R5: Stored bytes go into consecutive 32-bit words starting at the buffer address. Byte n of the frame lands in word n/4, bits 8*(n%4)+7 down to 8*(n%4). Unused bytes of the last word are written as zero.
- R6: When `strip_crc` is high, the last 4 bytes of the frame are not stored and are not counted in the written-back length.
- R7: A frame whose length, CRC included, exceeds `max_len` is too long. At most `max_len` bytes are stored. If the frame is accepted, status bit 19 and `int_sts[3]` are set. No word beyond the stored bytes is written.
- R8: A frame shorter than 64 bytes, CRC included, is a runt. It is rejected unless `accept_runt` is high. If accepted, it has status bit 22 set.
- R9: A frame whose last byte carries `in_crc_err` is rejected unless `accept_crc_err` is high. If accepted, it has status bit 17 set.
- R10: For an accepted frame, the written-back status word has the following fields:
  - owner bits 31:30 are 2'b00;
  - bit 16 is 1;
  - bit 20 is 1 only when none of the runt, too-long and CRC conditions holds;
  - bits 15:0 hold the stored length;
  - all other bits are 0.

  After the write-back, the writer moves to the next descriptor. A rejected frame leaves its descriptor unchanged, and the next frame reuses that descriptor.
- R11: Each accepted frame sets `int_sts[0]`, and also sets `int_sts[4]` when bit 20 is set. A 1 on `int_clr` clears the matching status bit. `irq` is high while any of bits 10, 4 or 0 is set together with its `int_en` bit. Bit 3 never raises `irq`.
- R12: A memory request holds `mem_valid`, `mem_addr`, `mem_write` and `mem_wdata` steady until `mem_ready`. Every address is word aligned.
- R13: Frames of random length, contents, CRC status and option settings are stored and reported as R5 to R10 describe, under random memory back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_on | input | 1 | Receive enable; low stops the writer and reloads the pointer |
| strip_crc | input | 1 | Drop the 4 CRC bytes from stored data |
| accept_crc_err | input | 1 | Keep frames with a CRC error |
| accept_runt | input | 1 | Keep frames shorter than 64 bytes |
| accept_long | input | 1 | Keep frames longer than `max_len` |
| max_len | input | LW | Maximum stored frame length in bytes |
| ring_base | input | AW | Address of the first descriptor |
| rx_demand | input | 1 | One-cycle receive-demand pulse |
| int_en | input | 11 | Interrupt enables (bits 10, 4, 0 used) |
| int_clr | input | 11 | Write-one-to-clear for `int_sts` |
| int_sts | output | 11 | Sticky interrupt status (bits 10, 4, 3, 0) |
| irq | output | 1 | Interrupt request |
| rx_active | output | 1 | Writer is running |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Writer accepts a byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_crc_err | input | 1 | With `in_last`: the frame failed its CRC |
| mem_valid | output | 1 | Memory request |
| mem_write | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high on a read |

## Verification
Directed frames cover the main cases:
- a plain 100-byte frame, which shows the byte-lane packing;
- a 70-byte frame with CRC stripping, which shows the 4-byte hold-back and the zero fill of the last word;
- CRC-error, runt and over-length frames, each sent once with its accept input low and once with it high.

The rejected sends show that the descriptor is left unchanged and that the following frame reuses it. The accepted sends show the flag bits and the truncated length. A software-owned descriptor and a low receive enable each stop the writer, and the following demand restarts it.

Random frames then mix lengths from 1 to 200 bytes, CRC errors, stripping, maximum lengths and accept settings, under random memory stalls. These show the interaction of truncation with stripping, and of runt with too-long.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OWN,
    S_BUF,
    S_NXT,
    S_STRM,
    S_FLSH,
    S_TAIL,
    S_WB,
    S_DROP
  } rxw_state_e;

  // Descriptor status word bit positions
  localparam int ST_RUNT = 22;
  localparam int ST_GOOD = 20;
  localparam int ST_LONG = 19;
  localparam int ST_CRCE = 17;
  localparam int ST_INTR = 16;

  // Interrupt status bit positions
  localparam int IS_NODESC = 10;
  localparam int IS_GOOD   = 4;
  localparam int IS_LONG   = 3;
  localparam int IS_RX     = 0;
  localparam int IS_W      = 11;

  localparam logic [1:0] OWN_ENGINE = 2'b10;

endpackage

// File: rtl/rxw_hold.sv
// Holds the most recent DEPTH bytes of a frame, so that the trailing CRC
// can be dropped without knowing in advance where the frame ends.
module rxw_hold #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic [CW-1:0] cnt,
  output logic          full
);

  logic [7:0] q [DEPTH];

  assign full = (cnt == CW'(DEPTH));
  assign dout = q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (push) begin
      if (full) begin
        for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
        q[DEPTH-1] <= din;
      end else begin
        for (int i = 0; i < DEPTH; i++)
          if (cnt == CW'(i)) q[i] <= din;
        cnt <= cnt + 1'b1;
      end
    end else if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) q[i] <= q[i+1];
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/rxw_pack.sv
// Packs bytes little-endian into one bus word; cleared lanes stay zero.
module rxw_pack #(
  parameter int BYTES = 4,
  localparam int WW = 8 * BYTES,
  localparam int CW = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    din,
  output logic [WW-1:0] word,
  output logic [CW-1:0] cnt,
  output logic          full
);

  assign full = (cnt == CW'(BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      cnt  <= '0;
    end else if (clr) begin
      word <= '0;
      cnt  <= '0;
    end else if (push) begin
      for (int j = 0; j < BYTES; j++)
        if (cnt == CW'(j)) word[8*j +: 8] <= din;
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxw_pkg::*;
#(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int MIN_FRAME = 64,
  parameter int CRC_LEN   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_on,
  input  logic          strip_crc,
  input  logic          accept_crc_err,
  input  logic          accept_runt,
  input  logic          accept_long,
  input  logic [LW-1:0] max_len,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_demand,
  input  logic [10:0]   int_en,
  input  logic [10:0]   int_clr,
  output logic [10:0]   int_sts,
  output logic          irq,
  output logic          rx_active,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_crc_err,
  output logic          mem_valid,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ready,
  input  logic [31:0]   mem_rdata
);

  localparam int WB_BYTES = 4;
  localparam int HCW = $clog2(CRC_LEN + 1);
  localparam int PCW = $clog2(WB_BYTES + 1);
  localparam logic [IS_W-1:0] IRQ_MASK =
      IS_W'((1 << IS_NODESC) | (1 << IS_GOOD) | (1 << IS_RX));

  rxw_state_e st, st_n;

  logic [AW-1:0] cur, dsc, bufa, nxt, woff;
  logic [LW-1:0] flen, slen;
  logic          crc_q;

  // hold line and packer
  logic           h_clr, h_push, h_pop, h_full;
  logic [7:0]     h_dout;
  logic [HCW-1:0] h_cnt;
  logic           pk_clr, pk_push, pk_full;
  logic [31:0]    pk_word;
  logic [PCW-1:0] pk_cnt;

  // per-cycle events
  logic frame_go, take_buf, take_nxt, data_done, wb_done, nodesc_hit, byte_in;

  logic is_runt, is_long, is_good, keep, room;
  logic [31:0] stat_word;
  logic [IS_W-1:0] sts_set;

  rxw_hold #(.DEPTH(CRC_LEN)) u_hold (
    .clk (clk), .rst_n (rst_n), .clr (h_clr), .push (h_push), .pop (h_pop),
    .din (in_data), .dout (h_dout), .cnt (h_cnt), .full (h_full)
  );

  rxw_pack #(.BYTES(WB_BYTES)) u_pack (
    .clk (clk), .rst_n (rst_n), .clr (pk_clr), .push (pk_push),
    .din (h_dout), .word (pk_word), .cnt (pk_cnt), .full (pk_full)
  );

  assign is_runt = flen < LW'(MIN_FRAME);
  assign is_long = flen > max_len;
  assign is_good = !is_runt && !is_long && !crc_q;
  assign keep    = (!is_runt || accept_runt) && (!is_long || accept_long) &&
                   (!crc_q || accept_crc_err);
  assign room    = slen < max_len;

  always_comb begin
    stat_word = '0;
    stat_word[LW-1:0] = slen;
    stat_word[ST_INTR] = 1'b1;
    stat_word[ST_CRCE] = crc_q;
    stat_word[ST_LONG] = is_long;
    stat_word[ST_GOOD] = is_good;
    stat_word[ST_RUNT] = is_runt;
  end

  always_comb begin
    st_n = st;
    mem_valid = 1'b0;
    mem_write = 1'b0;
    mem_addr  = dsc;
    mem_wdata = stat_word;
    in_ready  = 1'b0;
    h_clr = 1'b0; h_push = 1'b0; h_pop = 1'b0;
    pk_clr = 1'b0; pk_push = 1'b0;
    frame_go = 1'b0; take_buf = 1'b0; take_nxt = 1'b0;
    data_done = 1'b0; wb_done = 1'b0; nodesc_hit = 1'b0; byte_in = 1'b0;
    case (st)
      S_IDLE: begin
        if (in_valid) begin
          frame_go = rx_active;
          st_n = rx_active ? S_OWN : S_DROP;
        end
      end
      S_OWN: begin
        mem_valid = 1'b1;
        if (mem_ready) begin
          if (mem_rdata[31:30] == OWN_ENGINE) st_n = S_BUF;
          else begin
            nodesc_hit = 1'b1;
            st_n = S_DROP;
          end
        end
      end
      S_BUF: begin
        mem_valid = 1'b1;
        mem_addr  = dsc + AW'(4);
        if (mem_ready) begin
          take_buf = 1'b1;
          st_n = S_NXT;
        end
      end
      S_NXT: begin
        mem_valid = 1'b1;
        mem_addr  = dsc + AW'(12);
        if (mem_ready) begin
          take_nxt = 1'b1;
          h_clr = 1'b1;
          pk_clr = 1'b1;
          st_n = S_STRM;
        end
      end
      S_STRM: begin
        if (pk_full) begin
          mem_valid = 1'b1;
          mem_write = 1'b1;
          mem_addr  = bufa + woff;
          mem_wdata = pk_word;
          if (mem_ready) begin
            data_done = 1'b1;
            pk_clr = 1'b1;
          end
        end else begin
          in_ready = 1'b1;
          if (in_valid) begin
            byte_in = 1'b1;
            h_push  = 1'b1;
            pk_push = h_full && room;
            if (in_last) st_n = S_FLSH;
          end
        end
      end
      S_FLSH: begin
        if (pk_full) begin
          mem_valid = 1'b1;
          mem_write = 1'b1;
          mem_addr  = bufa + woff;
          mem_wdata = pk_word;
          if (mem_ready) begin
            data_done = 1'b1;
            pk_clr = 1'b1;
          end
        end else if (strip_crc || h_cnt == '0) begin
          h_clr = 1'b1;
          st_n = S_TAIL;
        end else begin
          h_pop = 1'b1;
          pk_push = room;
        end
      end
      S_TAIL: begin
        if (pk_cnt != '0) begin
          mem_valid = 1'b1;
          mem_write = 1'b1;
          mem_addr  = bufa + woff;
          mem_wdata = pk_word;
          if (mem_ready) begin
            data_done = 1'b1;
            pk_clr = 1'b1;
            st_n = keep ? S_WB : S_IDLE;
          end
        end else begin
          st_n = keep ? S_WB : S_IDLE;
        end
      end
      S_WB: begin
        mem_valid = 1'b1;
        mem_write = 1'b1;
        if (mem_ready) begin
          wb_done = 1'b1;
          st_n = S_IDLE;
        end
      end
      S_DROP: begin
        in_ready = 1'b1;
        if (in_valid && in_last) st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_comb begin
    sts_set = '0;
    sts_set[IS_NODESC] = nodesc_hit;
    sts_set[IS_RX]     = wb_done;
    sts_set[IS_GOOD]   = wb_done && is_good;
    sts_set[IS_LONG]   = wb_done && is_long;
  end

  assign irq = |(int_sts & int_en & IRQ_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0; dsc <= '0; bufa <= '0; nxt <= '0; woff <= '0;
      flen <= '0; slen <= '0; crc_q <= 1'b0;
      rx_active <= 1'b0;
      int_sts <= '0;
    end else begin
      st <= st_n;
      if (frame_go) dsc <= cur;
      if (take_buf) bufa <= {mem_rdata[AW-1:2], 2'b00};
      if (take_nxt) begin
        nxt   <= {mem_rdata[AW-1:2], 2'b00};
        woff  <= '0;
        flen  <= '0;
        slen  <= '0;
        crc_q <= 1'b0;
      end
      if (byte_in) begin
        if (flen != '1) flen <= flen + 1'b1;
        if (in_last) crc_q <= in_crc_err;
      end
      if (pk_push) slen <= slen + 1'b1;
      if (data_done) woff <= woff + AW'(WB_BYTES);

      if (!rx_on) rx_active <= 1'b0;
      else if (rx_demand) rx_active <= 1'b1;
      else if (nodesc_hit) rx_active <= 1'b0;

      if (!rx_on) cur <= {ring_base[AW-1:2], 2'b00};
      else if (wb_done) cur <= nxt;

      int_sts <= (int_sts & ~int_clr) | sts_set;
    end
  end

endmodule

// File: rtl/rx_desc_writer_chk.sv
module rx_desc_writer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_on,
  input logic          rx_active,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [10:0]   int_sts,
  input logic          irq
);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

  // R12
  mem_wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write && !mem_ready |=> $stable(mem_wdata));

  // R12
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  // R2
  rxoff_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |=> !rx_active);

  // R4
  nodesc_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_sts[10]) |-> $past(mem_valid && mem_ready && !mem_write));

  // R11
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_sts != 11'd0);

endmodule

bind rx_desc_writer rx_desc_writer_chk #(.AW(AW)) u_chk (
  .clk (clk), .rst_n (rst_n), .rx_on (rx_on), .rx_active (rx_active),
  .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_write (mem_write),
  .mem_addr (mem_addr), .mem_wdata (mem_wdata), .int_sts (int_sts), .irq (irq)
);

// File: tb/rx_desc_writer_bench.sv
`timescale 1ns/100ps
module rx_desc_writer_bench;

  localparam logic [31:0] SENT = 32'hA5A5_5A5A;
  localparam logic [31:0] OWNED = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_on = 1'b0, strip_crc = 1'b0, accept_crc_err = 1'b0;
  logic accept_runt = 1'b0, accept_long = 1'b0;
  logic [15:0] max_len = 16'd1518;
  logic [31:0] ring_base = 32'h100;
  logic rx_demand = 1'b0;
  logic [10:0] int_en = '0, int_clr = '0;
  logic [10:0] int_sts;
  logic irq, rx_active;
  logic in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic mem_valid, mem_write, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:1023];
  int tests = 0, fails = 0, di = 0, bad_bus = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rx_desc_writer u_rx_desc_writer (
    .clk (clk), .rst_n (rst_n), .rx_on (rx_on), .strip_crc (strip_crc),
    .accept_crc_err (accept_crc_err), .accept_runt (accept_runt),
    .accept_long (accept_long), .max_len (max_len), .ring_base (ring_base),
    .rx_demand (rx_demand), .int_en (int_en), .int_clr (int_clr),
    .int_sts (int_sts), .irq (irq), .rx_active (rx_active),
    .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
    .in_last (in_last), .in_crc_err (in_crc_err),
    .mem_valid (mem_valid), .mem_write (mem_write), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_ready (mem_ready), .mem_rdata (mem_rdata)
  );

  // memory model with bus-rule monitor
  assign mem_rdata = mem[mem_addr[11:2]];
  logic pend = 1'b0;
  logic [31:0] pend_addr = '0;
  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) mem[mem_addr[11:2]] <= mem_wdata;
    if (mem_valid && mem_addr[1:0] != 2'b00) bad_bus <= bad_bus + 1;
    if (pend && (!mem_valid || mem_addr != pend_addr)) bad_bus <= bad_bus + 1;
    pend <= rst_n && mem_valid && !mem_ready;
    pend_addr <= mem_addr;
  end

  initial begin
    mem_ready = 1'b0;
    forever begin
      @(negedge clk);
      mem_ready = ($urandom % 4) != 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int s, int i);
    return 8'(s * 31 + i * 7 + (i >> 3));
  endfunction

  function automatic bit exp_keep(int len, bit err);
    return (len >= 64 || accept_runt) && (len <= int'(max_len) || accept_long) &&
           (!err || accept_crc_err);
  endfunction

  function automatic int exp_slen(int len);
    int s = strip_crc ? (len > 4 ? len - 4 : 0) : len;
    return (s > int'(max_len)) ? int'(max_len) : s;
  endfunction

  function automatic logic [31:0] exp_stat(int len, bit err);
    logic [31:0] w = '0;
    bit runt = len < 64;
    bit lng = len > int'(max_len);
    w[15:0] = 16'(exp_slen(len));
    w[16] = 1'b1;
    w[17] = err;
    w[19] = lng;
    w[20] = !runt && !lng && !err;
    w[22] = runt;
    return w;
  endfunction

  task automatic send(input int len, input bit err, input int seed);
    bit ok;
    @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data = pat(seed, i);
      in_last = (i == len - 1);
      in_crc_err = err && (i == len - 1);
      do begin
        #1 ok = in_ready;
        @(negedge clk);
      end while (!ok);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
    in_crc_err = 1'b0;
  endtask

  task automatic pulse_demand();
    @(negedge clk) rx_demand = 1'b1;
    @(negedge clk) rx_demand = 1'b0;
  endtask

  task automatic clear_ints();
    @(negedge clk) int_clr = '1;
    @(negedge clk) int_clr = '0;
  endtask

  // Sends a frame to the expected descriptor and checks everything it affects.
  task automatic run_frame(input int len, input bit err, input int seed, input string tg);
    int d = 'h100 + 16 * di;
    int b = 'h400 + 'h100 * di;
    bit k;
    int s, first_bad;
    logic [31:0] ew, aw, ebad;
    logic [10:0] eis;
    @(negedge clk);
    mem[d >> 2] = OWNED;
    for (int w = 0; w < 64; w++) mem[(b >> 2) + w] = SENT;
    send(len, err, seed);
    repeat (40) @(negedge clk);
    k = exp_keep(len, err);
    s = exp_slen(len);
    eis = '0;
    if (k) begin
      check(mem[d >> 2] == exp_stat(len, err), tg, mem[d >> 2], exp_stat(len, err));
      first_bad = -1; aw = '0; ebad = '0;
      for (int w = 0; w < (s + 3) / 4; w++) begin
        for (int j = 0; j < 4; j++)
          ew[8*j +: 8] = (4 * w + j < s) ? pat(seed, 4 * w + j) : 8'h00;
        if (first_bad < 0 && mem[(b >> 2) + w] != ew) begin
          first_bad = w; aw = mem[(b >> 2) + w]; ebad = ew;
        end
      end
      check(first_bad < 0, "R5 data", aw, ebad);
      check(mem[(b >> 2) + (s + 3) / 4] == SENT, "R7 no write past end",
            mem[(b >> 2) + (s + 3) / 4], SENT);
      eis[0] = 1'b1;
      eis[4] = exp_stat(len, err)[20];
      eis[3] = len > int'(max_len);
      di = (di + 1) % 4;
    end else begin
      check(mem[d >> 2] == OWNED, {tg, " rejected, R10 descriptor kept"}, mem[d >> 2], OWNED);
    end
    check(int_sts == eis, "R11 status", 32'(int_sts), 32'(eis));
    check(irq == |(eis & int_en & 11'h411), "R11 irq", 32'(irq), 32'(|(eis & int_en & 11'h411)));
    clear_ints();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    for (int i = 0; i < 4; i++) begin
      mem[('h100 + 16 * i) >> 2]     = OWNED;
      mem[('h104 + 16 * i) >> 2]     = ('h400 + 'h100 * i) | 32'h3;   // R3 masking
      mem[('h108 + 16 * i) >> 2]     = 32'h1234_5678;
      mem[('h10C + 16 * i) >> 2]     = ('h100 + 16 * ((i + 1) % 4)) | 32'h2;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!rx_active && !irq && !mem_valid && !in_ready && int_sts == '0, "R1 reset",
          {rx_active, irq, mem_valid, in_ready, int_sts}, '0);

    rx_on = 1'b1;
    pulse_demand();
    check(rx_active, "R2 demand starts", 32'(rx_active), 1);

    // R3/R5/R10 plain frame, R6 strip
    run_frame(100, 1'b0, 1, "R3 R10 plain");
    strip_crc = 1'b1;
    run_frame(70, 1'b0, 2, "R6 strip");
    strip_crc = 1'b0;

    // R9 crc error rejected then accepted
    int_en = 11'h411;
    run_frame(90, 1'b1, 3, "R9 crc");
    accept_crc_err = 1'b1;
    run_frame(90, 1'b1, 4, "R9 crc");
    accept_crc_err = 1'b0;

    // R8 runt rejected then accepted
    run_frame(40, 1'b0, 5, "R8 runt");
    accept_runt = 1'b1;
    run_frame(40, 1'b0, 6, "R8 runt");
    accept_runt = 1'b0;

    // R7 too long; bit 3 alone never raises irq
    max_len = 16'd80;
    int_en = 11'h008;
    run_frame(120, 1'b0, 7, "R7 long");
    accept_long = 1'b1;
    run_frame(120, 1'b0, 8, "R7 long");
    accept_long = 1'b0;
    max_len = 16'd1518;

    // R4 software-owned descriptor
    int_en = 11'h400;
    @(negedge clk);
    mem[('h100 + 16 * di) >> 2] = 32'h4000_0000;
    mem[('h400 + 'h100 * di) >> 2] = SENT;
    send(80, 1'b0, 9);
    repeat (40) @(negedge clk);
    check(int_sts == 11'h400, "R4 unavailable status", 32'(int_sts), 32'h400);
    check(!rx_active, "R4 writer stopped", 32'(rx_active), 0);
    check(irq, "R11 irq from bit 10", 32'(irq), 1);
    check(mem[('h100 + 16 * di) >> 2] == 32'h4000_0000, "R4 descriptor kept",
          mem[('h100 + 16 * di) >> 2], 32'h4000_0000);
    send(80, 1'b0, 10);
    repeat (20) @(negedge clk);
    check(mem[('h400 + 'h100 * di) >> 2] == SENT, "R2 stopped writer stores nothing",
          mem[('h400 + 'h100 * di) >> 2], SENT);
    clear_ints();
    check(!irq && int_sts == '0, "R11 clear", 32'(int_sts), 0);
    pulse_demand();
    run_frame(66, 1'b0, 11, "R4 resumed");

    // R2 receive off reloads pointer
    @(negedge clk) rx_on = 1'b0;
    @(negedge clk);
    check(!rx_active, "R2 rx off", 32'(rx_active), 0);
    mem[('h400 + 'h100 * di) >> 2] = SENT;
    send(70, 1'b0, 12);
    repeat (20) @(negedge clk);
    check(mem[('h400 + 'h100 * di) >> 2] == SENT, "R2 off frame discarded",
          mem[('h400 + 'h100 * di) >> 2], SENT);
    rx_on = 1'b1;
    pulse_demand();
    di = 0;
    run_frame(64, 1'b0, 13, "R2 restart at ring base");

    // R13 random mix
    int_en = 11'h411;
    for (int n = 0; n < 24; n++) begin
      int len = 1 + int'($urandom % 200);
      bit err = ($urandom % 4) == 0;
      strip_crc = $urandom % 2;
      accept_crc_err = ($urandom % 4) != 0;
      accept_runt = ($urandom % 4) != 0;
      accept_long = ($urandom % 4) != 0;
      max_len = 16'(60 + $urandom % 161);
      run_frame(len, err, 100 + n, "R13 random");
    end

    check(bad_bus == 0, "R12 bus rules", 32'(bad_bus), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule